// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This peripheral gives several processors a shared place to trade 32-bit words. It holds a set of small hardware queues behind a 32-bit register bus. A store to a queue's message register appends a word. A load from that register removes the oldest word and returns it. Software polls each queue through a full flag and a count of waiting words, or it relies on interrupts.

Each processor, called a user here, owns a status register and an enable register. Every queue has two events: a word arrived, and the queue left the full state. Each event sets its bit in the status register of every user. A user's interrupt line is high while any of its status bits is set together with the matching enable bit. Software acknowledges an event by writing a one to its status bit.

Bus accesses complete in a single cycle. Read data is combinational from the address of the current read. Every side effect of a read or write takes hold at the next rising clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty (count reads 0), every status and enable bit is 0, and every interrupt output is low.
- R2: Offset 0x000 is a read-only revision register that reads 0x21 (major revision 2 in bits 7:4, minor revision 1 in bits 3:0). Writes to it are ignored.
- R3: For queue m, a write to offset 0x040+4·m appends a word. A read of that offset returns the oldest word and removes it, so words come back in the order they were written.
- R4: Offset 0x080+4·m reads 1 while queue m holds 4 words and 0 otherwise. A write to a full queue is dropped, and the queue's count and contents stay unchanged.
- R5: Offset 0x0C0+4·m reads the number of words held in queue m. A read of an empty queue's message register returns 0 and changes nothing.
- R6: Every accepted write to queue m sets bit 2·m in the status register of every user.
- R7: A read that takes queue m from full to not full sets bit 2·m+1 in the status register of every user.
- R8: User u's status register is at 0x100+8·u. Writing it clears each bit written as 1 and leaves each bit written as 0 unchanged. A read in the next access already returns the cleared value.
- R9: User u's enable register is at 0x104+8·u. It is plain read/write over its low 8 bits, and its upper bits read 0.
- R10: Interrupt output u is high exactly when some bit is set in both user u's status register and user u's enable register.
- R11: Unmapped offsets read 0 and ignore writes. This includes queue indices of 4 and above, user indices of 4 and above, and the gaps between regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A bus access is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current read access |
| irq_out | output | 4 | Level interrupt, one per user |

## Verification
The hardest event to produce is the not-full event. The bench must fill a queue to its last slot and then pop it, and only that exact pop may set the bit. The stimulus pushes four words and then tries a fifth, which must be dropped. It then pops once and checks that the not-full bit rose in every user's status at the same time. Finally it acknowledges bits in one user and confirms that the other users still hold their copies, which shows that status is kept per user while events are broadcast.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NQ    = 4,
  parameter int DEPTH = 4,
  parameter int NU    = 4,
  parameter int DW    = 32,
  parameter int AW    = 12,
  parameter logic [7:0] REVISION = 8'h21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic [NU-1:0] irq_out
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 2 * NQ;

  logic [DW-1:0] mem  [NQ][DEPTH];
  logic [PW-1:0] wp   [NQ];
  logic [PW-1:0] rp   [NQ];
  logic [CW-1:0] cnt  [NQ];
  logic [EW-1:0] stat [NU];
  logic [EW-1:0] en   [NU];

  logic [NQ-1:0] push, pop, wr_msg, rd_msg;
  logic [EW-1:0] evt;

  wire [3:0] qidx    = req_addr[5:2];
  wire [4:0] uidx    = req_addr[7:3];
  wire       aligned = req_addr[1:0] == 2'b00;
  wire       q_area  = aligned && req_addr[AW-1:8] == '0 && req_addr[7:6] != 2'b00 && int'(qidx) < NQ;
  wire       u_area  = aligned && int'(req_addr[AW-1:8]) == 1 && int'(uidx) < NU;
  wire       do_wr   = req_valid && req_write;
  wire       do_rd   = req_valid && !req_write;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    wire hit = q_area && req_addr[7:6] == 2'b01 && int'(qidx) == q;
    wire full = cnt[q] == CW'(DEPTH);
    assign wr_msg[q] = do_wr && hit;
    assign rd_msg[q] = do_rd && hit;
    assign push[q]   = wr_msg[q] && !full;
    assign pop[q]    = rd_msg[q] && cnt[q] != '0;
    assign evt[2*q]   = push[q];
    assign evt[2*q+1] = pop[q] && full;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp[q]  <= '0;
        rp[q]  <= '0;
        cnt[q] <= '0;
      end else begin
        if (push[q]) wp[q] <= (int'(wp[q]) == DEPTH - 1) ? '0 : wp[q] + 1'b1;
        if (pop[q])  rp[q] <= (int'(rp[q]) == DEPTH - 1) ? '0 : rp[q] + 1'b1;
        if (push[q] && !pop[q]) cnt[q] <= cnt[q] + 1'b1;
        else if (pop[q] && !push[q]) cnt[q] <= cnt[q] - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push[q]) mem[q][wp[q]] <= req_wdata;
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[q] <= CW'(DEPTH));
    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_msg[q] && full) |=> ($stable(cnt[q]) && $stable(wp[q])));
    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_msg[q] && cnt[q] == '0) |-> rsp_rdata == '0);

    for (genvar u = 0; u < NU; u++) begin : g_chk
      assert_newmsg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push[q] |=> stat[u][2*q]);
      assert_notfull_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop[q] && full) |=> stat[u][2*q+1]);
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    wire hit_s = do_wr && u_area && int'(uidx) == u && !req_addr[2];
    wire hit_e = do_wr && u_area && int'(uidx) == u &&  req_addr[2];
    wire [EW-1:0] ack = hit_s ? req_wdata[EW-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat[u] <= '0;
        en[u]   <= '0;
      end else begin
        stat[u] <= (stat[u] & ~ack) | evt;
        if (hit_e) en[u] <= req_wdata[EW-1:0];
      end
    end

    assign irq_out[u] = |(stat[u] & en[u]);

    assert_irq_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_out[u]);
  end

  always_comb begin
    rsp_rdata = '0;
    if (do_rd) begin
      if (req_addr == '0) rsp_rdata = DW'(REVISION);
      for (int q = 0; q < NQ; q++) begin
        if (q_area && int'(qidx) == q) begin
          case (req_addr[7:6])
            2'b01:   rsp_rdata = (cnt[q] != '0) ? mem[q][rp[q]] : '0;
            2'b10:   rsp_rdata = DW'(cnt[q] == CW'(DEPTH));
            default: rsp_rdata = DW'(cnt[q]);
          endcase
        end
      end
      for (int u = 0; u < NU; u++) begin
        if (u_area && int'(uidx) == u) rsp_rdata = req_addr[2] ? DW'(en[u]) : DW'(stat[u]);
      end
    end
  end
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [3:0]  irq_out;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  always @(negedge clk) begin
    #1;
    if (req_valid && !req_write && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rsp_rdata !== e) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, req_addr, rsp_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    @(negedge clk);
    #1;
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq_out, e);
    end
  endtask

  task automatic run();
    chk_irq(4'b0000, "R1 irq low after reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(4'b0000, "R1 irq low after release");
    rd(12'h0C0, 0, "R1 queue0 count");
    rd(12'h0CC, 0, "R1 queue3 count");
    rd(12'h100, 0, "R1 user0 status");
    rd(12'h11C, 0, "R1 user3 enable");

    rd(12'h000, 32'h21, "R2 revision");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h21, "R2 revision after write");

    wr(12'h040, 32'hA0A0_0001);
    wr(12'h040, 32'hB0B0_0002);
    rd(12'h080, 0, "R4 not full at two");
    wr(12'h040, 32'hC0C0_0003);
    wr(12'h040, 32'hD0D0_0004);
    rd(12'h080, 1, "R4 full at four");
    rd(12'h0C0, 4, "R5 count four");
    wr(12'h040, 32'hEEEE_EEEE);
    rd(12'h0C0, 4, "R4 dropped write keeps count");
    rd(12'h108, 32'h01, "R6 user1 new-message bit0");
    rd(12'h118, 32'h01, "R6 user3 new-message bit0");

    rd(12'h040, 32'hA0A0_0001, "R3 first out");
    rd(12'h100, 32'h03, "R7 user0 not-full bit1");
    rd(12'h110, 32'h03, "R7 user2 not-full bit1");
    rd(12'h080, 0, "R4 not full after pop");
    rd(12'h040, 32'hB0B0_0002, "R3 second out");
    rd(12'h040, 32'hC0C0_0003, "R3 third out");
    rd(12'h040, 32'hD0D0_0004, "R3 fourth out, dropped word absent");
    rd(12'h040, 0, "R5 empty read returns zero");
    rd(12'h0C0, 0, "R5 count zero after empty read");
    rd(12'h100, 32'h03, "R7 no extra event from empty read");

    wr(12'h100, 32'h0000_0001);
    rd(12'h100, 32'h02, "R8 ack bit0 only");
    rd(12'h108, 32'h03, "R8 other user untouched");

    wr(12'h114, 32'hFFFF_FFFF);
    rd(12'h114, 32'hFF, "R9 enable low bits only");
    chk_irq(4'b0100, "R10 user2 raised");
    wr(12'h110, 32'h03);
    chk_irq(4'b0000, "R10 user2 lowered by ack");
    rd(12'h110, 0, "R8 user2 cleared");

    wr(12'h04C, 32'h1234_5678);
    rd(12'h100, 32'h42, "R6 queue3 sets bit6");
    chk_irq(4'b0100, "R10 only enabled user");
    rd(12'h0CC, 1, "R5 queue3 count one");
    rd(12'h0C0, 0, "R5 queue0 unaffected");
    rd(12'h04C, 32'h1234_5678, "R3 queue3 word");

    wr(12'h0F0, 32'hDEAD_BEEF);
    rd(12'h0F0, 0, "R11 gap reads zero");
    wr(12'h050, 32'hCAFE_F00D);
    rd(12'h050, 0, "R11 queue index four");
    rd(12'h0C0, 0, "R11 write to queue index four ignored");
    wr(12'h120, 32'hFF);
    rd(12'h120, 0, "R11 user index four");
    rd(12'h104, 0, "R11 user0 enable untouched");
    rd(12'h042, 0, "R11 misaligned offset");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule